// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Link

This block models a single channel of a digital isolation link built from two halves: a transmit side that turns a logic level into short coded pulses, and a receive side that rebuilds the level from them. The transmitter does not send the level itself. It resynchronises the input, removes short glitches, and then emits a one-cycle "set" pulse when the filtered level rises and a one-cycle "clear" pulse when it falls. When the level sits still, the transmitter sends refresh pulses that repeat the current level. This keeps the receiver correct at DC even if an edge pulse was lost.

The receiver is a set/clear latch. A watchdog on this side forces the output to its default high state when no pulse has arrived for a programmed number of cycles, which is how an unpowered transmit side shows up at the output. Each side has an enable input that stands in for its supply being present. All timing (synchroniser depth, minimum pulse width, idle time before the first refresh, refresh period and watchdog timeout) is counted in clock cycles and set by parameters. The coded pulses are brought out as ports so that the link traffic can be observed.

Top module: `pulse_iso_link`

## Requirements
- R1: Each transition of the filtered input produces exactly one pulse, one cycle wide: a set pulse (`link_set`) for a rise and a clear pulse (`link_clr`) for a fall. With the input driven just after a clock edge, the pulse is visible after SYNC_STAGES+MIN_PW_CYCLES+1 edges and `dout` follows after SYNC_STAGES+MIN_PW_CYCLES+2 edges.
- R2: While the receiver is enabled, a set pulse alone makes `dout` 1 on the next edge and a clear pulse alone makes it 0. Between pulses `dout` holds its value, so a passed input pulse of width W cycles gives a `dout` high time of W cycles.
- R3: When no pulse has been sent for IDLE_CYCLES cycles after an edge pulse or an enable pulse, the transmitter sends a refresh pulse whose kind matches the filtered level (set for 1, clear for 0).
- R4: While the input stays idle, further refresh pulses of the same kind follow every REFRESH_CYCLES cycles.
- R5: If the enabled receiver has sampled no pulse for WDOG_CYCLES cycles, `dout` goes to 1 and stays at 1 until a pulse arrives. A clear pulse after the timeout brings `dout` back to 0. While the transmitter is enabled, the watchdog never fires.
- R6: While `tx_en` is 0, no pulses are sent and input changes have no effect. After the watchdog timeout, `dout` stays at 1 whatever `din` does.
- R7: On the first cycle in which `tx_en` is 1 after being 0 (including the first cycle after reset), a pulse carrying the current filtered level is sent at once.
- R8: An input pulse of either polarity shorter than MIN_PW_CYCLES cycles produces no link pulse and does not change `dout`. A pulse of MIN_PW_CYCLES cycles or longer passes.
- R9: While `rx_en` is 0, `dout` is 1 on the next edge and pulses are ignored. After `rx_en` returns to 1, `dout` follows the next pulse, which arrives within REFRESH_CYCLES cycles on an idle input.
- R10: Set and clear are never asserted in the same cycle. If both arrive, the receiver keeps its current output.
- R11: During reset `dout` is 1 and neither pulse is asserted. All counters start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit side powered |
| rx_en | input | 1 | Receive side powered |
| din | input | 1 | Logic input to be carried across the link |
| link_set | output | 1 | Coded set pulse from transmitter to receiver |
| link_clr | output | 1 | Coded clear pulse from transmitter to receiver |
| dout | output | 1 | Reconstructed logic output, default high |

## Verification
The bench sweeps input pulse widths on both sides of the glitch threshold. A filter that is off by one would either pass a width of MIN_PW_CYCLES-1 or swallow a width of exactly MIN_PW_CYCLES, and an edge detector placed wrongly would give an output high time different from the input's. It measures the spacing of refresh pulses, which exposes a first refresh that reuses the periodic spacing or a refresh whose kind disagrees with the level. It times the watchdog rise against the last pulse to the exact cycle. It also drives the enable inputs, where a missing state pulse on transmit enable would leave the output stuck high, and a receiver that listened while disabled would pull the output low.

// File: rtl/pil_pkg.sv
package pil_pkg;

   typedef struct packed {
      logic set;
      logic clr;
   } link_pulse_t;

   function automatic int pil_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int pil_cw(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pil_sync.sv
module pil_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stage;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= 1'b0;
            else        stage[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= 1'b0;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/pil_glitch_filter.sv
module pil_glitch_filter #(
   parameter int MIN_PW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import pil_pkg::*;

   logic filt_q;

   if (MIN_PW <= 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_q <= 1'b0;
         else        filt_q <= d;
      end
   end else begin : g_count
      localparam int CW = pil_cw(MIN_PW);
      localparam logic [CW-1:0] LIM = CW'(MIN_PW - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
         end else if (d == filt_q) begin
            run_q  <= '0;
         end else if (run_q == LIM) begin
            filt_q <= d;
            run_q  <= '0;
         end else begin
            run_q  <= run_q + 1'b1;
         end
      end
   end

   assign q = filt_q;
endmodule

// File: rtl/pil_tx_encoder.sv
module pil_tx_encoder #(
   parameter int IDLE_CYCLES    = 125,
   parameter int REFRESH_CYCLES = 108
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 lvl,
   output pil_pkg::link_pulse_t pulse
);
   import pil_pkg::*;

   localparam int MAXC = pil_max(IDLE_CYCLES, REFRESH_CYCLES);
   localparam int CW   = pil_cw(MAXC);
   localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYCLES - 1);
   localparam logic [CW-1:0] REF_LIM  = CW'(REFRESH_CYCLES - 1);

   logic          lvl_q, en_q, periodic_q;
   logic [CW-1:0] quiet_q;
   logic          edge_hit, en_rise, due, fire;
   link_pulse_t   pulse_q;

   assign edge_hit = lvl ^ lvl_q;
   assign en_rise  = en & ~en_q;
   assign due      = periodic_q ? (quiet_q == REF_LIM) : (quiet_q == IDLE_LIM);
   assign fire     = en & (edge_hit | en_rise | due);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q      <= 1'b0;
         en_q       <= 1'b0;
         periodic_q <= 1'b0;
         quiet_q    <= '0;
         pulse_q    <= '0;
      end else begin
         lvl_q       <= lvl;
         en_q        <= en;
         pulse_q.set <= fire & lvl;
         pulse_q.clr <= fire & ~lvl;
         if (!en) begin
            quiet_q    <= '0;
            periodic_q <= 1'b0;
         end else if (fire) begin
            quiet_q    <= '0;
            periodic_q <= ~(edge_hit | en_rise);
         end else begin
            quiet_q    <= quiet_q + 1'b1;
         end
      end
   end

   assign pulse = pulse_q;
endmodule

// File: rtl/pil_rx_decoder.sv
module pil_rx_decoder #(
   parameter int WDOG_CYCLES = 625
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  pil_pkg::link_pulse_t pulse,
   output logic                 dout
);
   import pil_pkg::*;

   localparam int CW = pil_cw(WDOG_CYCLES);
   localparam logic [CW-1:0] LIM = CW'(WDOG_CYCLES - 1);

   logic          out_q;
   logic [CW-1:0] silent_q;
   logic          one_kind;

   assign one_kind = pulse.set ^ pulse.clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= 1'b1;
         silent_q <= '0;
      end else if (!en) begin
         out_q    <= 1'b1;
         silent_q <= '0;
      end else if (one_kind) begin
         out_q    <= pulse.set;
         silent_q <= '0;
      end else if (silent_q == LIM) begin
         out_q    <= 1'b1;
      end else begin
         silent_q <= silent_q + 1'b1;
      end
   end

   assign dout = out_q;
endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link #(
   parameter int SYNC_STAGES    = 2,
   parameter int MIN_PW_CYCLES  = 3,
   parameter int IDLE_CYCLES    = 125,
   parameter int REFRESH_CYCLES = 108,
   parameter int WDOG_CYCLES    = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic rx_en,
   input  logic din,
   output logic link_set,
   output logic link_clr,
   output logic dout
);
   import pil_pkg::*;

   localparam int MAX_GAP = pil_max(IDLE_CYCLES, REFRESH_CYCLES);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (MIN_PW_CYCLES < 1) begin : g_bad_pw
      $error("MIN_PW_CYCLES must be at least 1");
   end
   if (IDLE_CYCLES < 2 || REFRESH_CYCLES < 2) begin : g_bad_refresh
      $error("IDLE_CYCLES and REFRESH_CYCLES must be at least 2");
   end
   if (WDOG_CYCLES <= MAX_GAP + 1) begin : g_bad_wdog
      $error("WDOG_CYCLES must exceed the longest refresh gap plus one");
   end

   logic        din_sync, din_filt;
   link_pulse_t pulse;

   pil_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(din), .q(din_sync)
   );

   pil_glitch_filter #(.MIN_PW(MIN_PW_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .d(din_sync), .q(din_filt)
   );

   pil_tx_encoder #(
      .IDLE_CYCLES(IDLE_CYCLES), .REFRESH_CYCLES(REFRESH_CYCLES)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .lvl(din_filt), .pulse(pulse)
   );

   pil_rx_decoder #(.WDOG_CYCLES(WDOG_CYCLES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .pulse(pulse), .dout(dout)
   );

   assign link_set = pulse.set;
   assign link_clr = pulse.clr;
endmodule

// File: rtl/pulse_iso_link_chk.sv
module pulse_iso_link_chk #(
   parameter int SYNC_STAGES    = 2,
   parameter int MIN_PW_CYCLES  = 3,
   parameter int IDLE_CYCLES    = 125,
   parameter int REFRESH_CYCLES = 108,
   parameter int WDOG_CYCLES    = 625
) (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic rx_en,
   input logic link_set,
   input logic link_clr,
   input logic dout
);
   import pil_pkg::*;

   localparam int MAX_GAP = pil_max(IDLE_CYCLES, REFRESH_CYCLES);
   localparam int RW = $clog2(WDOG_CYCLES + 1);
   localparam int TW = $clog2(MAX_GAP + 1);
   localparam logic [RW-1:0] RSAT = RW'(WDOG_CYCLES);
   localparam logic [TW-1:0] TSAT = TW'(MAX_GAP);

   logic [RW-1:0] rx_gap;
   logic [TW-1:0] tx_gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_gap <= '0;
         tx_gap <= '0;
      end else begin
         if (!rx_en || link_set || link_clr) rx_gap <= '0;
         else if (rx_gap != RSAT)           rx_gap <= rx_gap + 1'b1;
         if (!tx_en || link_set || link_clr) tx_gap <= '0;
         else if (tx_gap != TSAT)           tx_gap <= tx_gap + 1'b1;
      end
   end

   p_set_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      link_set |=> !link_set);
   p_clr_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      link_clr |=> !link_clr);
   p_set_drives_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && link_set && !link_clr) |=> dout);
   p_clr_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && link_clr && !link_set) |=> !dout);
   p_fall_needs_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout) |-> $past(link_clr));
   p_refresh_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_gap < TSAT);
   p_wdog_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gap == RSAT) |-> dout);
   p_tx_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!link_set && !link_clr));
   p_rx_off_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> dout);
   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_set && link_clr));
endmodule

bind pulse_iso_link pulse_iso_link_chk #(
   .SYNC_STAGES(SYNC_STAGES), .MIN_PW_CYCLES(MIN_PW_CYCLES),
   .IDLE_CYCLES(IDLE_CYCLES), .REFRESH_CYCLES(REFRESH_CYCLES),
   .WDOG_CYCLES(WDOG_CYCLES)
) u_chk (.*);

// File: tb/pulse_iso_link_test.sv
module pulse_iso_link_test;
   localparam int SYNC = 2;
   localparam int MINPW = 3;
   localparam int IDLE = 20;
   localparam int REFR = 12;
   localparam int WDOG = 50;
   localparam int LAT = SYNC + MINPW + 2;

   logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b1, rx_en = 1'b1, din = 1'b0;
   logic link_set, link_clr, dout;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int set_cnt = 0, clr_cnt = 0, both_cnt = 0, last_pulse_cyc = 0;

   pulse_iso_link #(
      .SYNC_STAGES(SYNC), .MIN_PW_CYCLES(MINPW), .IDLE_CYCLES(IDLE),
      .REFRESH_CYCLES(REFR), .WDOG_CYCLES(WDOG)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .din(din),
      .link_set(link_set), .link_clr(link_clr), .dout(dout)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (link_set) begin set_cnt++; last_pulse_cyc = cyc; end
         if (link_clr) begin clr_cnt++; last_pulse_cyc = cyc; end
         if (link_set && link_clr) both_cnt++;
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic wait_pulse(output int at, output int kind);
      at = -1; kind = -1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (link_set || link_clr) begin
            at = cyc; kind = link_set ? 1 : 0;
            return;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int c0, c1, c2, c3, k0, k1, k2, k3, k, hi, s0, lows, tot0;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk_eq("R11 dout in reset", dout, 1);
      chk_eq("R11 pulses in reset", link_set | link_clr, 0);
      rst_n = 1'b1;

      // R7: state pulse right after reset with tx enabled
      @(negedge clk);
      chk_eq("R7 clear pulse after reset", link_clr, 1);
      @(negedge clk);
      chk_eq("R7 dout low after reset pulse", dout, 0);
      repeat (5) @(negedge clk);

      // R1: latency of a rise and a fall
      din = 1'b1; k = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (dout && k == 0) k = i;
      end
      chk_eq("R1 rise latency", k, LAT);
      din = 1'b0; k = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (!dout && k == 0) k = i;
      end
      chk_eq("R1 fall latency", k, LAT);
      repeat (5) @(negedge clk);

      // R8 / R2: high pulse width sweep
      for (int w = 1; w <= 6; w++) begin
         s0 = set_cnt; hi = 0;
         din = 1'b1;
         for (int i = 1; i <= w + LAT + 4; i++) begin
            @(negedge clk);
            if (dout) hi++;
            if (i == w) din = 1'b0;
         end
         chk_eq("R8 set pulses for high glitch", set_cnt - s0, (w >= MINPW) ? 1 : 0);
         chk_eq("R2 dout high width", hi, (w >= MINPW) ? w : 0);
         repeat (IDLE + 5) @(negedge clk);
      end

      // R8: low pulse width sweep from a high level
      din = 1'b1;
      repeat (LAT + 4) @(negedge clk);
      for (int w = 1; w <= 5; w++) begin
         s0 = clr_cnt; lows = 0;
         din = 1'b0;
         for (int i = 1; i <= w + LAT + 4; i++) begin
            @(negedge clk);
            if (!dout) lows++;
            if (i == w) din = 1'b1;
         end
         chk_eq("R8 clear pulses for low glitch", clr_cnt - s0, (w >= MINPW) ? 1 : 0);
         chk_eq("R2 dout low width", lows, (w >= MINPW) ? w : 0);
         repeat (IDLE + 5) @(negedge clk);
      end
      din = 1'b0;
      repeat (LAT + 4) @(negedge clk);

      // R3 / R4: refresh spacing and kind, both levels
      for (int lv = 1; lv >= 0; lv--) begin
         din = lv[0];
         wait_pulse(c0, k0);
         wait_pulse(c1, k1);
         wait_pulse(c2, k2);
         wait_pulse(c3, k3);
         chk_eq("R1 edge pulse kind", k0, lv);
         chk_eq("R3 first refresh gap", c1 - c0, IDLE);
         chk_eq("R3 refresh kind", k1, lv);
         chk_eq("R4 periodic refresh gap", c2 - c1, REFR);
         chk_eq("R4 periodic refresh gap again", c3 - c2, REFR);
         chk_eq("R4 periodic refresh kind", k3, lv);
      end

      // R5: watchdog never fires while refreshed
      hi = 0;
      repeat (3 * WDOG) begin
         @(negedge clk);
         if (dout) hi++;
      end
      chk_eq("R5 no timeout with refresh", hi, 0);

      // R5 / R6: transmitter off, watchdog timing
      tx_en = 1'b0; k = -1;
      for (int i = 0; i < 3 * WDOG; i++) begin
         @(negedge clk);
         if (dout) begin k = cyc - last_pulse_cyc; break; end
      end
      chk_eq("R5 timeout after last pulse", k, WDOG + 1);

      // R6: input toggles while transmitter off
      tot0 = set_cnt + clr_cnt; lows = 0;
      for (int t = 0; t < 6; t++) begin
         din = ~din;
         repeat (10) begin
            @(negedge clk);
            if (!dout) lows++;
         end
      end
      chk_eq("R6 dout held high while tx off", lows, 0);
      chk_eq("R6 no pulses while tx off", set_cnt + clr_cnt - tot0, 0);
      din = 1'b0;
      repeat (LAT + 4) @(negedge clk);

      // R7 / R5: re-enable gives an immediate state pulse clearing the timeout
      tx_en = 1'b1;
      @(negedge clk);
      chk_eq("R7 state pulse on enable", link_clr, 1);
      @(negedge clk);
      chk_eq("R5 timeout cleared by pulse", dout, 0);
      repeat (5) @(negedge clk);

      // R9: receiver off then on
      rx_en = 1'b0;
      @(negedge clk);
      chk_eq("R9 dout high when rx off", dout, 1);
      lows = 0;
      repeat (30) begin
         @(negedge clk);
         if (!dout) lows++;
      end
      chk_eq("R9 pulses ignored when rx off", lows, 0);
      rx_en = 1'b1; k = -1;
      for (int i = 1; i <= 3 * REFR; i++) begin
         @(negedge clk);
         if (!dout) begin k = i; break; end
      end
      chk(k >= 1 && k <= REFR, "R9 recovery within refresh period", k, REFR);

      // R1 / R2: square wave at the minimum width
      repeat (IDLE + 5) @(negedge clk);
      s0 = set_cnt; hi = 0;
      for (int t = 0; t < 8; t++) begin
         din = ~din;
         repeat (MINPW) begin
            @(negedge clk);
            if (dout) hi++;
         end
      end
      repeat (LAT + 3) begin
         @(negedge clk);
         if (dout) hi++;
      end
      chk_eq("R1 set pulses for square wave", set_cnt - s0, 4);
      chk_eq("R2 square wave high time", hi, 4 * MINPW);
      chk_eq("R2 final level", dout, 0);

      // R10: set and clear never together
      chk_eq("R10 overlapping pulses", both_cnt, 0);

      finish_run();
   end
endmodule